// File: doc/BRIEF.md
# eMMC Boot-Mode Bus Monitor

This block listens to an eMMC bus without driving it. It is clocked by the bus clock and samples the command line and data line 0 on every rising edge. It reassembles host command frames from the command line, checks their CRC, and presents each good command as a one-cycle pulse that carries its index and argument.

On top of the command decoder it follows the two-step reset handshake that places a card in the alternative boot mode. The first step is a reset command carrying the pre-idle argument. The second is a reset command carrying the boot-request argument. While the boot stream runs, the monitor counts the clocks on data line 0 and keeps the most recent data bits in a shift window. Several images may be streamed back to back, so counting carries on until the next reset command ends the transfer.

The flags, the start and end pulses and the bit window are meant for logic that times an event against a known point in the boot stream.

Top module: `emmc_bootmon`

## Requirements
- R1: An active-low asynchronous reset immediately clears the state flags, the boot bit count, the boot bit window, the pulses and the frame receiver.
- R2: A frame is 48 bits sent MSB first: start bit 0, direction bit 1, 6-bit index, 32-bit argument, 7-bit CRC, end bit 1. For a well-formed frame, `cmd_valid_o` is high for exactly the one cycle after the edge that samples the end bit, and `cmd_index_o` and `cmd_arg_o` carry the index and argument during that cycle.
- R3: The CRC is the 7-bit code with polynomial x^7+x^3+1 and a zero seed, computed over the first 40 frame bits. A mismatch or an end bit of 0 raises `cmd_err_o` for one cycle instead of `cmd_valid_o`, and the frame changes no state.
- R4: A frame whose direction bit is 0 raises neither `cmd_valid_o` nor `cmd_err_o`.
- R5: A valid index-0 command with argument `PREIDLE_ARG` (default 0xF0F0F0F0), received outside the boot state, sets `preidle_o` one cycle after its valid pulse.
- R6: A valid index-0 command with argument `BOOTREQ_ARG` (default 0xFFFFFFFA), received while `preidle_o` is set, sets `boot_active_o` one cycle after the valid pulse. In that same cycle `boot_start_o` pulses and the count and the window read zero.
- R7: On each clock edge at which `boot_active_o` is high, the count grows by one and the sampled data line 0 bit enters the window at its LSB. Non-zero-index commands received during the transfer do not stop it.
- R8: Any valid index-0 command received in the boot state clears `boot_active_o` one cycle after its valid pulse, and `boot_end_o` pulses in that cycle. After that the count and the window hold their values until the next boot entry.
- R9: Outside the boot state, a valid index-0 command with any other argument, or with `BOOTREQ_ARG` when `preidle_o` is clear, returns the monitor to idle with both flags low.
- R10: Valid commands with a non-zero index never change the state.
- R11: With `BOOT_CNT_SAT` = 1, the count stops at its all-ones value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | eMMC bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 1 | Command line sample |
| dat0_i | input | 1 | Data line 0 sample |
| cmd_valid_o | output | 1 | One-cycle pulse for a good host command |
| cmd_err_o | output | 1 | One-cycle pulse for a host frame with a bad CRC or end bit |
| cmd_index_o | output | 6 | Command index, valid with the pulse |
| cmd_arg_o | output | 32 | Command argument, valid with the pulse |
| preidle_o | output | 1 | Pre-idle step seen |
| boot_active_o | output | 1 | Boot transfer running |
| boot_start_o | output | 1 | Pulse on boot entry |
| boot_end_o | output | 1 | Pulse on the reset that ends the transfer |
| boot_bits_o | output | BOOT_CNT_W | Clocks counted in the boot transfer |
| boot_window_o | output | BOOT_SHIFT_W | Last data line 0 bits of the transfer, newest at LSB |

## Verification
The assertions assume that the command line idles high between frames and that each frame is a complete 48-bit burst, so valid pulses are never closer than a frame length apart. They also assume that reset is only released between frames. The stimulus respects this: frames are sent whole, followed by idle-high gaps, and reset is released at a falling edge while the line is idle. Data line 0 is given a new random value every clock, and at each check the window is compared with a history of the sampled data kept by the bench.

// File: rtl/emmc_bootmon_pkg.sv
`timescale 1ns/1ps
package emmc_bootmon_pkg;
   localparam int FRAME_BITS = 48;
   localparam int CRC_SPAN   = 40;
   localparam int IDX_W      = 6;
   localparam int ARG_W      = 32;
   localparam int CRC_W      = 7;
   localparam int FCNT_W     = $clog2(FRAME_BITS);

   typedef enum logic [1:0] {
      BM_IDLE = 2'd0,
      BM_PRE  = 2'd1,
      BM_BOOT = 2'd2
   } bm_state_e;

   // one serial step of the x^7 + x^3 + 1 code
   function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      logic [CRC_W-1:0] n;
      fb = c[CRC_W-1] ^ b;
      n  = {c[CRC_W-2:0], 1'b0};
      if (fb) n = n ^ 7'h09;
      return n;
   endfunction
endpackage

// File: rtl/emmc_bootmon_rx.sv
`timescale 1ns/1ps
module emmc_bootmon_rx
   import emmc_bootmon_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cmd_i,
   output logic                  done_o,
   output logic [FRAME_BITS-1:0] frame_o,
   output logic [CRC_W-1:0]      crc_o
);
   localparam logic [FCNT_W-1:0] LAST_BIT = FCNT_W'(FRAME_BITS - 1);
   localparam logic [FCNT_W-1:0] SPAN     = FCNT_W'(CRC_SPAN);

   logic                  busy_q;
   logic [FCNT_W-1:0]     bit_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [CRC_W-1:0]      crc_q;
   logic                  done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         bit_q  <= '0;
         sh_q   <= '0;
         crc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (!cmd_i) begin
               busy_q <= 1'b1;
               bit_q  <= FCNT_W'(1);
               sh_q   <= {sh_q[FRAME_BITS-2:0], cmd_i};
               crc_q  <= crc7_step('0, cmd_i);
            end
         end else begin
            sh_q  <= {sh_q[FRAME_BITS-2:0], cmd_i};
            bit_q <= bit_q + FCNT_W'(1);
            if (bit_q < SPAN) crc_q <= crc7_step(crc_q, cmd_i);
            if (bit_q == LAST_BIT) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o  = done_q;
   assign frame_o = sh_q;
   assign crc_o   = crc_q;
endmodule

// File: rtl/emmc_bootmon_dec.sv
`timescale 1ns/1ps
module emmc_bootmon_dec
   import emmc_bootmon_pkg::*;
(
   input  logic                  done_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   input  logic [CRC_W-1:0]      crc_i,
   output logic                  valid_o,
   output logic                  err_o,
   output logic [IDX_W-1:0]      idx_o,
   output logic [ARG_W-1:0]      arg_o
);
   logic host_dir, start_ok, end_ok, crc_ok;

   always_comb begin
      start_ok = (frame_i[FRAME_BITS-1] == 1'b0);
      host_dir = frame_i[FRAME_BITS-2];
      end_ok   = frame_i[0];
      crc_ok   = (frame_i[CRC_W:1] == crc_i);
      valid_o  = done_i && start_ok && host_dir && end_ok && crc_ok;
      err_o    = done_i && start_ok && host_dir && !(end_ok && crc_ok);
      idx_o    = frame_i[FRAME_BITS-3 -: IDX_W];
      arg_o    = frame_i[CRC_W+ARG_W:CRC_W+1];
   end
endmodule

// File: rtl/emmc_bootmon_seq.sv
`timescale 1ns/1ps
module emmc_bootmon_seq
   import emmc_bootmon_pkg::*;
#(
   parameter int               CNT_W       = 24,
   parameter int               SHIFT_W     = 32,
   parameter bit               CNT_SAT     = 1'b1,
   parameter logic [ARG_W-1:0] PREIDLE_ARG = 32'hF0F0_F0F0,
   parameter logic [ARG_W-1:0] BOOTREQ_ARG = 32'hFFFF_FFFA
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               valid_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [ARG_W-1:0]   arg_i,
   input  logic               dat0_i,
   output logic               preidle_o,
   output logic               boot_o,
   output logic               start_o,
   output logic               end_o,
   output logic [CNT_W-1:0]   cnt_o,
   output logic [SHIFT_W-1:0] win_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   bm_state_e          st_q, st_d;
   logic               start_q, end_q;
   logic [CNT_W-1:0]   cnt_q, cnt_inc;
   logic [SHIFT_W-1:0] win_q;
   logic               reset_cmd;

   assign reset_cmd = valid_i && (idx_i == '0);

   always_comb begin
      st_d = st_q;
      if (reset_cmd) begin
         if (st_q == BM_BOOT)                                 st_d = BM_IDLE;
         else if (arg_i == PREIDLE_ARG)                       st_d = BM_PRE;
         else if (arg_i == BOOTREQ_ARG && st_q == BM_PRE)     st_d = BM_BOOT;
         else                                                 st_d = BM_IDLE;
      end
   end

   generate
      if (CNT_SAT) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
      end else begin : g_wrap
         assign cnt_inc = cnt_q + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= BM_IDLE;
         start_q <= 1'b0;
         end_q   <= 1'b0;
         cnt_q   <= '0;
         win_q   <= '0;
      end else begin
         st_q    <= st_d;
         start_q <= (st_q != BM_BOOT) && (st_d == BM_BOOT);
         end_q   <= (st_q == BM_BOOT) && (st_d != BM_BOOT);
         if (st_q == BM_BOOT) begin
            cnt_q <= cnt_inc;
            win_q <= {win_q[SHIFT_W-2:0], dat0_i};
         end else if (st_d == BM_BOOT) begin
            cnt_q <= '0;
            win_q <= '0;
         end
      end
   end

   assign preidle_o = (st_q == BM_PRE);
   assign boot_o    = (st_q == BM_BOOT);
   assign start_o   = start_q;
   assign end_o     = end_q;
   assign cnt_o     = cnt_q;
   assign win_o     = win_q;
endmodule

// File: rtl/emmc_bootmon.sv
`timescale 1ns/1ps
module emmc_bootmon
   import emmc_bootmon_pkg::*;
#(
   parameter int          BOOT_CNT_W   = 24,
   parameter int          BOOT_SHIFT_W = 32,
   parameter bit          BOOT_CNT_SAT = 1'b1,
   parameter logic [31:0] PREIDLE_ARG  = 32'hF0F0_F0F0,
   parameter logic [31:0] BOOTREQ_ARG  = 32'hFFFF_FFFA
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cmd_i,
   input  logic                    dat0_i,
   output logic                    cmd_valid_o,
   output logic                    cmd_err_o,
   output logic [5:0]              cmd_index_o,
   output logic [31:0]             cmd_arg_o,
   output logic                    preidle_o,
   output logic                    boot_active_o,
   output logic                    boot_start_o,
   output logic                    boot_end_o,
   output logic [BOOT_CNT_W-1:0]   boot_bits_o,
   output logic [BOOT_SHIFT_W-1:0] boot_window_o
);
   generate
      if (BOOT_CNT_W < 2 || BOOT_CNT_W > 48) begin : g_bad_cnt
         $error("emmc_bootmon: BOOT_CNT_W must lie in 2..48");
      end
      if (BOOT_SHIFT_W < 2 || BOOT_SHIFT_W > 256) begin : g_bad_win
         $error("emmc_bootmon: BOOT_SHIFT_W must lie in 2..256");
      end
      if (PREIDLE_ARG == BOOTREQ_ARG) begin : g_bad_arg
         $error("emmc_bootmon: the two handshake arguments must differ");
      end
   endgenerate

   logic                  fr_done;
   logic [FRAME_BITS-1:0] fr_bits;
   logic [CRC_W-1:0]      fr_crc;

   emmc_bootmon_rx u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_i   (cmd_i),
      .done_o  (fr_done),
      .frame_o (fr_bits),
      .crc_o   (fr_crc)
   );

   emmc_bootmon_dec u_dec (
      .done_i  (fr_done),
      .frame_i (fr_bits),
      .crc_i   (fr_crc),
      .valid_o (cmd_valid_o),
      .err_o   (cmd_err_o),
      .idx_o   (cmd_index_o),
      .arg_o   (cmd_arg_o)
   );

   emmc_bootmon_seq #(
      .CNT_W       (BOOT_CNT_W),
      .SHIFT_W     (BOOT_SHIFT_W),
      .CNT_SAT     (BOOT_CNT_SAT),
      .PREIDLE_ARG (PREIDLE_ARG),
      .BOOTREQ_ARG (BOOTREQ_ARG)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (cmd_valid_o),
      .idx_i     (cmd_index_o),
      .arg_i     (cmd_arg_o),
      .dat0_i    (dat0_i),
      .preidle_o (preidle_o),
      .boot_o    (boot_active_o),
      .start_o   (boot_start_o),
      .end_o     (boot_end_o),
      .cnt_o     (boot_bits_o),
      .win_o     (boot_window_o)
   );
endmodule

// File: rtl/emmc_bootmon_chk.sv
`timescale 1ns/1ps
module emmc_bootmon_chk #(
   parameter int          CNT_W       = 24,
   parameter logic [31:0] PREIDLE_ARG = 32'hF0F0_F0F0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cmd_valid_o,
   input logic             cmd_err_o,
   input logic [5:0]       cmd_index_o,
   input logic [31:0]      cmd_arg_o,
   input logic             preidle_o,
   input logic             boot_active_o,
   input logic             boot_start_o,
   input logic             boot_end_o,
   input logic [CNT_W-1:0] boot_bits_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   p_pulse_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cmd_valid_o && cmd_err_o));

   p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o |=> !cmd_valid_o);

   p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(preidle_o && boot_active_o));

   p_preidle_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_index_o == 6'd0 && cmd_arg_o == PREIDLE_ARG && !boot_active_o)
      |=> preidle_o);

   p_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_start_o |-> (boot_active_o && boot_bits_o == '0 && $past(preidle_o)));

   p_count_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boot_active_o && boot_bits_o != CMAX) |=> boot_bits_o == $past(boot_bits_o) + 1'b1);

   p_end_on_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_index_o == 6'd0 && boot_active_o) |=> (boot_end_o && !boot_active_o));

   p_end_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_end_o |-> (!boot_active_o && $past(boot_active_o)));

   p_count_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !boot_active_o |=> (boot_start_o || boot_bits_o == $past(boot_bits_o)));

   p_other_idx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_index_o != 6'd0) |=>
      (preidle_o == $past(preidle_o) && boot_active_o == $past(boot_active_o)));
endmodule

bind emmc_bootmon emmc_bootmon_chk #(
   .CNT_W       (BOOT_CNT_W),
   .PREIDLE_ARG (PREIDLE_ARG)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cmd_valid_o   (cmd_valid_o),
   .cmd_err_o     (cmd_err_o),
   .cmd_index_o   (cmd_index_o),
   .cmd_arg_o     (cmd_arg_o),
   .preidle_o     (preidle_o),
   .boot_active_o (boot_active_o),
   .boot_start_o  (boot_start_o),
   .boot_end_o    (boot_end_o),
   .boot_bits_o   (boot_bits_o)
);

// File: tb/emmc_bootmon_bench.sv
`timescale 1ns/1ps
module emmc_bootmon_bench;
   localparam int          CW   = 10;
   localparam int          SW   = 32;
   localparam logic [31:0] PRE  = 32'hF0F0_F0F0;
   localparam logic [31:0] BOOT = 32'hFFFF_FFFA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd = 1'b1;
   logic          dat0 = 1'b0;
   logic          v, e, pre, bt, bs, be;
   logic [5:0]    idx;
   logic [31:0]   arg;
   logic [CW-1:0] bits;
   logic [SW-1:0] win;

   int          n_tests = 0;
   int          n_fail  = 0;
   int          cyc     = 0;
   logic [63:0] hist    = '0;
   bit          running = 1'b1;

   always #2 clk = ~clk;

   emmc_bootmon #(.BOOT_CNT_W(CW), .BOOT_SHIFT_W(SW)) u_emmc_bootmon (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .dat0_i(dat0),
      .cmd_valid_o(v), .cmd_err_o(e), .cmd_index_o(idx), .cmd_arg_o(arg),
      .preidle_o(pre), .boot_active_o(bt), .boot_start_o(bs), .boot_end_o(be),
      .boot_bits_o(bits), .boot_window_o(win)
   );

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      hist <= {hist[62:0], dat0};
   end

   always @(negedge clk) if (running) dat0 = 1'($urandom_range(1, 0));

   function automatic logic [6:0] ref_crc(input logic [39:0] d);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb = c[6] ^ d[i];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic int sat(input int n);
      return (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drives one frame; leaves time at the falling edge right after the end bit was sampled
   task automatic send(input logic dir, input logic [5:0] ix, input logic [31:0] a,
                       input logic bad_crc, input logic bad_end);
      logic [39:0] head = {1'b0, dir, ix, a};
      logic [47:0] f    = {head, ref_crc(head) ^ {6'd0, bad_crc}, ~bad_end};
      logic        ok   = !bad_crc && !bad_end;
      for (int i = 47; i >= 0; i--) begin
         @(negedge clk);
         cmd = f[i];
      end
      @(negedge clk);
      cmd = 1'b1;
      chk("R2/R4 valid pulse", v, dir && ok);
      chk("R3/R4 error pulse", e, dir && !ok);
      if (dir && ok) begin
         chk("R2 index", idx, ix);
         chk("R2 argument", arg, a);
      end
   endtask

   task automatic flags(input string tag, input logic p, input logic b);
      chk({tag, " preidle"}, pre, p);
      chk({tag, " boot"}, bt, b);
   endtask

   task automatic boot_run(input int gap, input int mids);
      int e0, f0;
      send(1, 0, PRE, 0, 0);
      @(negedge clk);
      flags("R5", 1, 0);
      send(1, 0, BOOT, 0, 0);
      e0 = cyc;
      @(negedge clk);
      flags("R6", 0, 1);
      chk("R6 start pulse", bs, 1);
      chk("R6 count cleared", bits, 0);
      chk("R6 window cleared", win, 0);
      for (int m = 0; m < mids; m++) begin
         idle($urandom_range(8, 2));
         send(1, 6'($urandom_range(63, 1)), $urandom, 0, 0);
         @(negedge clk);
         flags("R7 R10 transfer kept", 0, 1);
      end
      send(1, 0, PRE, 1, 0);
      @(negedge clk);
      flags("R3 bad reset ignored", 0, 1);
      idle(gap);
      send(1, 0, $urandom, 0, 0);
      f0 = cyc;
      @(negedge clk);
      flags("R8", 0, 0);
      chk("R8 end pulse", be, 1);
      chk("R7 R11 count", bits, sat(f0 - e0));
      chk("R7 window", win, hist[SW-1:0]);
      idle(4);
      chk("R8 count held", bits, sat(f0 - e0));
      chk("R8 end pulse single", be, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      idle(3);
      flags("R1 reset", 0, 0);
      chk("R1 count", bits, 0);
      chk("R1 window", win, 0);
      chk("R1 valid", v, 0);
      rst_n = 1'b1;
      idle(2);

      chk("R3 reference code", ref_crc(40'h40_0000_0000), 7'h4A);

      for (int i = 0; i < 12; i++) begin
         send(1, 6'($urandom_range(63, 1)), $urandom, 0, 0);
         idle($urandom_range(3, 0));
         flags("R10 idle kept", 0, 0);
      end

      send(1, 0, PRE, 1, 0); @(negedge clk); flags("R3 bad crc", 0, 0);
      send(1, 0, PRE, 0, 1); @(negedge clk); flags("R3 bad end", 0, 0);
      send(0, 0, PRE, 0, 0); @(negedge clk); flags("R4 device frame", 0, 0);
      send(1, 0, BOOT, 0, 0); @(negedge clk); flags("R9 boot without pre", 0, 0);
      send(1, 0, PRE, 0, 0); @(negedge clk); flags("R5", 1, 0);
      send(1, 0, PRE, 0, 0); @(negedge clk); flags("R5 repeat", 1, 0);
      send(1, 5, BOOT, 0, 0); @(negedge clk); flags("R10 in preidle", 1, 0);
      send(1, 0, 32'h1234_5678, 0, 0); @(negedge clk); flags("R9 other arg", 0, 0);

      boot_run(60, 0);
      boot_run(45, 2);
      for (int r = 0; r < 3; r++) boot_run($urandom_range(200, 40), $urandom_range(3, 0));
      boot_run(1100, 1);

      send(1, 0, PRE, 0, 0);
      send(1, 0, BOOT, 0, 0);
      idle(50);
      #1 rst_n = 1'b0;
      #0.5;
      flags("R1 async", 0, 0);
      chk("R1 async count", bits, 0);
      chk("R1 async window", win, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      flags("R1 after release", 0, 0);

      running = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule